// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is one logic cell of a sum-of-products programmable fabric. Five local product terms, already formed by an AND array outside the block, are gathered into an OR sum. That sum can also absorb a cascade input from a neighbouring cell, and it is passed on to the next cell through a cascade output. The sum then goes through an XOR polarity stage. After that comes a storage element that a static configuration word can set to act as a D, T, JK or SR flip-flop or as a flow-through latch. The configuration word also picks the register's data source, its clock source, an optional clock enable, asynchronous clear and preset sources, and whether the pin output and the buried feedback come from the register or from the XOR stage.

The block runs on a fast sampling clock `clk`. The global clocks and the product-term clock are sampled as levels, and the storage element acts on each observed 0-to-1 transition of the selected source. Asynchronous clear and preset force the visible register value in the same cycle they are asserted, with no clock transition needed. The stored state is then overwritten on the next sampling edge.

Top module: `plm_macrocell`

## Requirements
- R1: `casc_out` is the OR of every `pt[i]` whose enable bit `cfg[i]` (bits 4..0) is 1, ORed with `casc_in` when `cfg[5]` is 1.
- R2: The XOR stage output is the OR sum XOR an operand picked by `cfg[7:6]`: 00 gives 0, 01 gives 1, 10 or 11 gives `pt[4]`. When `cfg[19]` is 0, `pin_out` shows the XOR output.
- R3: The register data input is picked by `cfg[9:8]`: 00 the XOR output, 01 `pt[3]`, 10 or 11 `pin_in`.
- R4: The clock source is picked by `cfg[14:13]`: 0, 1 and 2 select `gclk[0..2]`, and 3 selects `pt[1]`. The state changes only on a `clk` edge where the selected source is sampled 1 after it was sampled 0 on the previous `clk` edge. After reset the previous sample counts as 1.
- R5: When `cfg[15]` is 1 and a global clock is selected, `pt[0]` low blocks every transition and keeps the latch closed. With the product-term clock, `pt[0]` has no effect.
- R6: In mode `cfg[12:10]`=0 (D, as are codes 5 to 7) a counted transition loads the data input. In mode 1 (T) a data input of 1 inverts the state.
- R7: In mode 2 (JK), J is the data input and K is `pt[2]`. J=K=1 inverts the state, J alone sets it, K alone clears it, and neither holds it.
- R8: In mode 3 (SR), S is the data input and R is `pt[2]`. S alone sets the state, R alone clears it, and S=R=1 or S=R=0 holds it.
- R9: In mode 4 (latch), the visible value follows the data input while the selected clock is high and enabled, and holds the last value while it is low.
- R10: The clear source is picked by `cfg[17:16]`: 0 none, 1 `gclr`, 2 `pt[3]`, 3 `gclr` OR `pt[3]`. While the clear is active the visible value is 0 in the same cycle, and the state is 0 afterwards.
- R11: When `cfg[18]` is 1, `pt[4]` presets the visible value to 1 in the same cycle. Clear wins over preset.
- R12: `pin_out` shows the visible register value when `cfg[19]` is 1. `fb_out` shows the visible register value when `cfg[20]` is 1, and the XOR output otherwise.
- R13: `oe_out` is picked by `cfg[22:21]`: 00 gives 0, 01 gives 1, 10 gives `pt[0]`, 11 gives the inverse of `pt[0]`.
- R14: While `rst_n` is low the state is 0, so a registered `pin_out` reads 0 when no preset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the cell state |
| gclk | input | 3 | Global clock levels |
| gclr | input | 1 | Global clear |
| pt | input | 5 | Local product terms |
| casc_in | input | 1 | Cascade sum from the neighbouring cell |
| pin_in | input | 1 | Pin input value |
| cfg | input | 23 | Static configuration word |
| pin_out | output | 1 | Pin output value |
| oe_out | output | 1 | Pin output enable |
| fb_out | output | 1 | Buried feedback |
| casc_out | output | 1 | Cascade sum to the next cell |

## Verification
The hardest case to reach from the ports is a counted clock transition that falls in the same cycle as a low clock enable or an active clear or preset. This matters most in the JK and SR modes, where J=K=1 and S=R=1 must also be seen together. The stimulus holds each random configuration for forty cycles and toggles the clock levels at random. It keeps the clear and preset product terms high only a quarter of the time, so that both the gated and the ungated transitions happen often in every mode. A behavioural model in the bench predicts all four outputs on every cycle.

// File: rtl/plm_pkg.sv
package plm_pkg;
    parameter int PT_N   = 5;
    parameter int GCLK_N = 3;
    localparam int CS_W  = $clog2(GCLK_N + 1);
    localparam int CFG_W = PT_N + 18;

    // roles of the local product terms
    localparam int PT_CE = 0;
    localparam int PT_CK = 1;
    localparam int PT_KR = 2;
    localparam int PT_CL = 3;
    localparam int PT_PS = 4;

    localparam logic [2:0] RM_T   = 3'd1;
    localparam logic [2:0] RM_JK  = 3'd2;
    localparam logic [2:0] RM_SR  = 3'd3;
    localparam logic [2:0] RM_LAT = 3'd4;

    typedef struct packed {
        logic [1:0]      oe_sel;
        logic            fb_reg;
        logic            out_reg;
        logic            ps_en;
        logic [1:0]      cl_sel;
        logic            ce_en;
        logic [CS_W-1:0] ck_sel;
        logic [2:0]      rmode;
        logic [1:0]      d_sel;
        logic [1:0]      x_sel;
        logic            casc_en;
        logic [PT_N-1:0] sum_en;
    } cfg_t;
endpackage

// File: rtl/plm_sum.sv
module plm_sum
    import plm_pkg::*;
(
    input  logic [PT_N-1:0] pt,
    input  logic [PT_N-1:0] sum_en,
    input  logic            casc_en,
    input  logic            casc_in,
    input  logic [1:0]      x_sel,
    input  logic            x_pt,
    output logic            sum,
    output logic            xo
);
    logic [PT_N-1:0] routed;
    logic            x_op;

    genvar g;
    generate
        for (g = 0; g < PT_N; g++) begin : g_route
            assign routed[g] = pt[g] & sum_en[g];
        end
    endgenerate

    always_comb begin
        sum = (|routed) | (casc_en & casc_in);
        unique case (x_sel)
            2'b00:   x_op = 1'b0;
            2'b01:   x_op = 1'b1;
            default: x_op = x_pt;
        endcase
        xo = sum ^ x_op;
    end
endmodule

// File: rtl/plm_clk.sv
module plm_clk
    import plm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GCLK_N-1:0] gclk,
    input  logic              pt_ck,
    input  logic              pt_ce,
    input  logic [CS_W-1:0]   ck_sel,
    input  logic              ce_en,
    output logic              lvl,
    output logic              rise,
    output logic              ce_ok
);
    typedef struct packed {
        logic prev;
    } ck_st_t;

    ck_st_t st_d, st_q;
    logic [GCLK_N-1:0] hit;
    logic              is_glob;

    genvar g;
    generate
        for (g = 0; g < GCLK_N; g++) begin : g_pick
            assign hit[g] = (ck_sel == CS_W'(g)) & gclk[g];
        end
    endgenerate

    always_comb begin
        is_glob   = ck_sel < CS_W'(GCLK_N);
        lvl       = is_glob ? (|hit) : pt_ck;
        rise      = lvl & ~st_q.prev;
        ce_ok     = ~(ce_en & is_glob) | pt_ce;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= 1'b1;
        else        st_q      <= st_d;
    end
endmodule

// File: rtl/plm_store.sv
module plm_store
    import plm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rmode,
    input  logic       d_in,
    input  logic       k_in,
    input  logic       lvl,
    input  logic       rise,
    input  logic       ce_ok,
    input  logic       clr,
    input  logic       pre,
    output logic       q_vis
);
    typedef struct packed {
        logic state;
    } rg_st_t;

    rg_st_t st_d, st_q;
    logic   is_lat;
    logic   lat_open;
    logic   edge_val;

    always_comb begin
        is_lat   = (rmode == RM_LAT);
        lat_open = is_lat & lvl & ce_ok;
        unique case (rmode)
            RM_T:    edge_val = st_q.state ^ d_in;
            RM_JK:   edge_val = (d_in & ~st_q.state) | (~k_in & st_q.state);
            RM_SR:   edge_val = d_in ? (k_in ? st_q.state : 1'b1)
                                     : (k_in ? 1'b0 : st_q.state);
            default: edge_val = d_in;
        endcase

        st_d = st_q;
        if (clr)               st_d.state = 1'b0;
        else if (pre)          st_d.state = 1'b1;
        else if (is_lat)       begin
            if (lat_open)      st_d.state = d_in;
        end
        else if (rise & ce_ok) st_d.state = edge_val;

        if (clr)           q_vis = 1'b0;
        else if (pre)      q_vis = 1'b1;
        else if (lat_open) q_vis = d_in;
        else               q_vis = st_q.state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.state <= 1'b0;
        else        st_q       <= st_d;
    end

    // R4
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !is_lat && !clr && !pre) |=> $stable(st_q.state));
    // R5
    ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_ok && !clr && !pre) |=> $stable(st_q.state));
    // R8
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode == RM_SR && d_in && k_in && !clr && !pre) |=> $stable(st_q.state));
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
    import plm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GCLK_N-1:0] gclk,
    input  logic              gclr,
    input  logic [PT_N-1:0]   pt,
    input  logic              casc_in,
    input  logic              pin_in,
    input  logic [CFG_W-1:0]  cfg,
    output logic              pin_out,
    output logic              oe_out,
    output logic              fb_out,
    output logic              casc_out
);
    cfg_t c;
    logic sum, xo, d_in, lvl, rise, ce_ok, clr, pre, q_vis;

    assign c = cfg_t'(cfg);

    plm_sum u_sum (
        .pt(pt), .sum_en(c.sum_en), .casc_en(c.casc_en), .casc_in(casc_in),
        .x_sel(c.x_sel), .x_pt(pt[PT_PS]), .sum(sum), .xo(xo)
    );

    plm_clk u_clk (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .pt_ck(pt[PT_CK]),
        .pt_ce(pt[PT_CE]), .ck_sel(c.ck_sel), .ce_en(c.ce_en),
        .lvl(lvl), .rise(rise), .ce_ok(ce_ok)
    );

    always_comb begin
        unique case (c.d_sel)
            2'b00:   d_in = xo;
            2'b01:   d_in = pt[PT_CL];
            default: d_in = pin_in;
        endcase
        unique case (c.cl_sel)
            2'd0:    clr = 1'b0;
            2'd1:    clr = gclr;
            2'd2:    clr = pt[PT_CL];
            default: clr = gclr | pt[PT_CL];
        endcase
        pre = c.ps_en & pt[PT_PS];
        unique case (c.oe_sel)
            2'b00:   oe_out = 1'b0;
            2'b01:   oe_out = 1'b1;
            2'b10:   oe_out = pt[PT_CE];
            default: oe_out = ~pt[PT_CE];
        endcase
        pin_out  = c.out_reg ? q_vis : xo;
        fb_out   = c.fb_reg  ? q_vis : xo;
        casc_out = sum;
    end

    plm_store u_store (
        .clk(clk), .rst_n(rst_n), .rmode(c.rmode), .d_in(d_in),
        .k_in(pt[PT_KR]), .lvl(lvl), .rise(rise), .ce_ok(ce_ok),
        .clr(clr), .pre(pre), .q_vis(q_vis)
    );

    // R10
    clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !q_vis);
    // R11
    preset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr) |-> q_vis);
    // R1
    casc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c.sum_en == '0 && c.casc_en) |-> (casc_out == casc_in));
endmodule

// File: tb/plm_macrocell_tb.sv
module plm_macrocell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  gclk = '0;
    logic        gclr = 1'b0;
    logic [4:0]  pt = '0;
    logic        casc_in = 1'b0;
    logic        pin_in = 1'b0;
    logic [22:0] cfg = '0;
    logic        pin_out, oe_out, fb_out, casc_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit m_state = 0;
    bit m_prev = 1;

    always #2.5 clk = ~clk;

    plm_macrocell dut_i (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .gclr(gclr), .pt(pt),
        .casc_in(casc_in), .pin_in(pin_in), .cfg(cfg),
        .pin_out(pin_out), .oe_out(oe_out), .fb_out(fb_out), .casc_out(casc_out)
    );

    function automatic bit f_sum();
        bit s = 0;
        for (int i = 0; i < 5; i++) if (cfg[i] && pt[i]) s = 1;
        if (cfg[5] && casc_in) s = 1;
        return s;
    endfunction

    function automatic bit f_xor();
        bit op = (cfg[7:6] == 2'b00) ? 0 : (cfg[7:6] == 2'b01) ? 1 : pt[4];
        return f_sum() != op;
    endfunction

    function automatic bit f_data();
        if (cfg[9:8] == 2'b00) return f_xor();
        if (cfg[9:8] == 2'b01) return pt[3];
        return pin_in;
    endfunction

    function automatic bit f_lvl();
        return (cfg[14:13] == 2'd3) ? pt[1] : gclk[cfg[14:13]];
    endfunction

    function automatic bit f_ce();
        return (cfg[15] && cfg[14:13] != 2'd3) ? pt[0] : 1'b1;
    endfunction

    function automatic bit f_clr();
        case (cfg[17:16])
            2'd0: return 0;
            2'd1: return gclr;
            2'd2: return pt[3];
            default: return gclr || pt[3];
        endcase
    endfunction

    function automatic bit f_pre();
        return cfg[18] && pt[4];
    endfunction

    function automatic bit f_q();
        if (f_clr()) return 0;
        if (f_pre()) return 1;
        if (cfg[12:10] == 3'd4 && f_lvl() && f_ce()) return f_data();
        return m_state;
    endfunction

    function automatic bit f_oe();
        case (cfg[22:21])
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return pt[0];
            default: return !pt[0];
        endcase
    endfunction

    function automatic string reg_tag();
        if (f_clr()) return "R10";
        if (f_pre()) return "R11";
        case (cfg[12:10])
            3'd1: return "R6 T";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R6 D";
        endcase
    endfunction

    // behavioural reference: one update per sampling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            m_prev  = 1;
        end else begin
            bit lv, dd, kk, go;
            lv = f_lvl();
            dd = f_data();
            kk = pt[2];
            go = lv && !m_prev && f_ce();
            if (f_clr()) m_state = 0;
            else if (f_pre()) m_state = 1;
            else if (cfg[12:10] == 3'd4) begin
                if (lv && f_ce()) m_state = dd;
            end else if (go) begin
                case (cfg[12:10])
                    3'd1: if (dd) m_state = !m_state;
                    3'd2: begin
                        if (dd && kk) m_state = !m_state;
                        else if (dd) m_state = 1;
                        else if (kk) m_state = 0;
                    end
                    3'd3: begin
                        if (dd && !kk) m_state = 1;
                        else if (!dd && kk) m_state = 0;
                    end
                    default: m_state = dd;
                endcase
            end
            m_prev = lv;
        end
    end

    task automatic chk(input string tag, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", casc_out, f_sum());
        chk(cfg[19] ? reg_tag() : "R2", pin_out, cfg[19] ? f_q() : f_xor());
        chk(cfg[20] ? "R3/R4/R5/R12" : "R12 comb", fb_out, cfg[20] ? f_q() : f_xor());
        chk("R13", oe_out, f_oe());
    endtask

    task automatic drive_random();
        gclk    = 3'($urandom);
        gclr    = ($urandom % 8) == 0;
        pt      = 5'($urandom);
        pt[3]   = ($urandom % 4) == 0;
        pt[4]   = ($urandom % 4) == 0;
        casc_in = 1'($urandom);
        pin_in  = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset: D mode, registered pin, no clear or preset
        cfg = 23'h080000 | 23'h000001;
        pt  = 5'b00001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        gclk = 3'b111;
        @(negedge clk);
        chk("R14", pin_out, 1'b0);
        gclk = 3'b000;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14", pin_out, 1'b0);

        for (int k = 0; k < 300; k++) begin
            cfg = 23'($urandom);
            if (k % 3 == 0) cfg[17:16] = 2'd0;
            if (k % 4 == 0) cfg[18] = 1'b0;
            for (int n = 0; n < 40; n++) begin
                drive_random();
                @(negedge clk);
                compare_all();
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule